// File: doc/BRIEF.md
# Message-Signalled Interrupt Forwarding Engine

This block turns wired interrupt sources into message-signalled interrupts. Each implemented source keeps a pending flag, an enable flag and a destination word. When the domain-wide enable is on, the engine finds a source whose pending and enable flags are both set, copies the destination fields (hart index, guest index, interrupt identity) into an outgoing message and offers it on a valid/ready port. The source's pending flag is cleared when the message is accepted. A separate generate-message command sends one message to an arbitrary hart and identity, with the guest index forced to zero.

The engine sits behind a register decoder that is not part of this block. That decoder delivers already-decoded commands: an operation code, a source index and a 32-bit data word. Input events from the wired sources arrive on a separate strobe that carries a source index. The memory write that places a message into an interrupt file happens downstream of the message port.

Top module: `msi_fwd_engine`

## Requirements
- R1: While the domain enable (bit 0 of the data word of operation 0) is clear, no source message is emitted. A source that is pending and enabled during that time is emitted once the domain enable is set.
- R2: A pending source whose enable flag is clear emits nothing. Setting its enable (operation 4) while it is still pending causes its message to be emitted.
- R3: A source message carries hart = destination[31:18], guest = destination[17:12] and identity = destination[10:0], taken from that source's destination word (operation 1).
- R4: A destination write keeps bits 31:12 and 10:0 and stores zero in bit 11. The read port `tgtRdData` returns the stored word for `tgtRdIdx`.
- R5: Each time a pending flag is set, the source sends exactly one message. The flag remains set until the handshake is accepted and is cleared on acceptance, so no repeat message follows.
- R6: When several sources are ready together, their messages leave in ascending source-number order, one per accepted handshake.
- R7: Once `msiValid` is raised, it stays high and the hart, guest and identity fields stay unchanged until `msiReady` is seen. This holds even if the destination word of that source is rewritten in the meantime.
- R8: A generate-message command (operation 6) sends one message with hart = data[31:18], guest = 0 and identity = data[10:0]. The domain enable does not gate it. `genValue` holds the data with bits 17:12 cleared. A waiting generated message goes out before any waiting source message.
- R9: Indexed operations (1 to 5) and input events whose index is 0 or above `NUM_SRC` have no effect. The read port returns 0 for such indices.
- R10: An input event (`evtValid` with `evtIdx`) sets that source's pending flag. The source is then forwarded if it is enabled and the domain is on.
- R11: After reset, `msiValid` is low, every destination word reads 0 and `genValue` is 0.
- R12: Clearing the pending flag (operation 3) or the enable flag (operation 5) of a source that has not yet been granted prevents its message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Decoded command strobe |
| cmdOp | input | 3 | 0 domain, 1 destination, 2 set pending, 3 clear pending, 4 set enable, 5 clear enable, 6 generate message, 7 none |
| cmdIdx | input | IDX_W | Source index for operations 1 to 5 |
| cmdData | input | 32 | Command data word |
| evtValid | input | 1 | Input event strobe |
| evtIdx | input | IDX_W | Source index of the input event |
| msiValid | output | 1 | Message offered |
| msiReady | input | 1 | Message taken |
| msiHart | output | 14 | Destination hart index |
| msiGuest | output | 6 | Destination guest index |
| msiId | output | 11 | Interrupt identity |
| tgtRdIdx | input | IDX_W | Destination read index |
| tgtRdData | output | 32 | Stored destination word |
| genValue | output | 32 | Stored generate-message word |

## Verification
The assertions assume the consumer follows the handshake: it may hold `msiReady` low for any number of cycles, and it does not depend on a message being taken back. They also assume that a command and an input event that name the same source in one cycle resolve with the set taking priority. The bench drives each command or event for exactly one cycle, away from the clock edge. It raises `msiReady` only after it has seen `msiValid`, and it covers the held-message case by keeping `msiReady` low across several cycles while unrelated commands arrive.

// File: rtl/msi_fwd_pkg.sv
package msi_fwd_pkg;

  localparam int WORD_W    = 32;
  localparam int HART_LSB  = 18;
  localparam int HART_W    = 14;
  localparam int GUEST_LSB = 12;
  localparam int GUEST_W   = 6;
  localparam int ID_LSB    = 0;
  localparam int ID_W      = 11;

  // bits a destination word may keep: hart, guest and identity fields
  localparam logic [WORD_W-1:0] TGT_KEEP    = 32'hFFFF_F7FF;
  // guest field position, cleared in the stored generate-message word
  localparam logic [WORD_W-1:0] GUEST_FIELD = 32'h0003_F000;

  typedef enum logic [2:0] {
    OP_DOMAIN  = 3'd0,
    OP_TARGET  = 3'd1,
    OP_SETPEND = 3'd2,
    OP_CLRPEND = 3'd3,
    OP_SETEN   = 3'd4,
    OP_CLREN   = 3'd5,
    OP_GENMSI  = 3'd6,
    OP_NONE    = 3'd7
  } cmd_op_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadSrc;  // capture lowest ready source into the message registers
    logic loadGen;  // capture the generate-message word
    logic ackSrc;   // held source message accepted: drop its pending flag
  } fwd_strobe_t;

endpackage

// File: rtl/msi_fwd_datapath.sv
module msi_fwd_datapath
  import msi_fwd_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [2:0]         cmdOp,
  input  logic [IDX_W-1:0]   cmdIdx,
  input  logic [WORD_W-1:0]  cmdData,
  input  logic               evtValid,
  input  logic [IDX_W-1:0]   evtIdx,
  input  fwd_strobe_t        strobe,
  input  logic [IDX_W-1:0]   tgtRdIdx,
  output logic               domainEn,
  output logic               genPending,
  output logic               readyAny,
  output logic [IDX_W-1:0]   readyIdx,
  output logic [IDX_W-1:0]   grantIdx,
  output logic [HART_W-1:0]  msiHart,
  output logic [GUEST_W-1:0] msiGuest,
  output logic [ID_W-1:0]    msiId,
  output logic [WORD_W-1:0]  tgtRdData,
  output logic [WORD_W-1:0]  genValue,
  output logic [(1<<IDX_W)-1:0] pendVec,
  output logic [(1<<IDX_W)-1:0] enVec
);

  localparam int IDX_SPAN = 1 << IDX_W;

  cmd_op_e opCode;
  logic    genWrite;
  logic    domainWrite;
  logic [WORD_W-1:0] tgtArr [IDX_SPAN];

  assign opCode      = cmd_op_e'(cmdOp);
  assign genWrite    = cmdValid && (opCode == OP_GENMSI);
  assign domainWrite = cmdValid && (opCode == OP_DOMAIN);

  // per-source state; slot 0 and slots above NUM_SRC are not implemented
  for (genvar s = 0; s < IDX_SPAN; s++) begin : g_slot
    if (s >= 1 && s <= NUM_SRC) begin : g_live
      logic hitCmd, hitEvt, hitAck;
      logic setPend, clrPend, setEn, clrEn, tgtWrite;
      logic pendQ, enQ;
      logic [WORD_W-1:0] tgtQ;

      always_comb begin
        hitCmd   = cmdValid && (cmdIdx == IDX_W'(s));
        hitEvt   = evtValid && (evtIdx == IDX_W'(s));
        hitAck   = strobe.ackSrc && (grantIdx == IDX_W'(s));
        setPend  = (hitCmd && (opCode == OP_SETPEND)) || hitEvt;
        clrPend  = (hitCmd && (opCode == OP_CLRPEND)) || hitAck;
        setEn    = hitCmd && (opCode == OP_SETEN);
        clrEn    = hitCmd && (opCode == OP_CLREN);
        tgtWrite = hitCmd && (opCode == OP_TARGET);
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          pendQ <= 1'b0;
          enQ   <= 1'b0;
          tgtQ  <= '0;
        end else begin
          // a new set wins over a clear in the same cycle
          if (setPend)      pendQ <= 1'b1;
          else if (clrPend) pendQ <= 1'b0;
          if (setEn)        enQ   <= 1'b1;
          else if (clrEn)   enQ   <= 1'b0;
          if (tgtWrite)     tgtQ  <= cmdData & TGT_KEEP;
        end
      end

      assign pendVec[s] = pendQ;
      assign enVec[s]   = enQ;
      assign tgtArr[s]  = tgtQ;
    end else begin : g_void
      assign pendVec[s] = 1'b0;
      assign enVec[s]   = 1'b0;
      assign tgtArr[s]  = '0;
    end
  end

  // lowest-numbered ready source: scan downward, last hit wins
  always_comb begin
    readyAny = 1'b0;
    readyIdx = '0;
    for (int s = IDX_SPAN - 1; s >= 1; s--) begin
      if (pendVec[s] && enVec[s]) begin
        readyAny = 1'b1;
        readyIdx = IDX_W'(s);
      end
    end
  end

  assign tgtRdData = tgtArr[tgtRdIdx];

  // domain enable and generate-message word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      domainEn   <= 1'b0;
      genValue   <= '0;
      genPending <= 1'b0;
    end else begin
      if (domainWrite) domainEn <= cmdData[0];
      if (genWrite) begin
        genValue   <= cmdData & ~GUEST_FIELD;
        genPending <= 1'b1;
      end else if (strobe.loadGen) begin
        genPending <= 1'b0;
      end
    end
  end

  // outgoing message registers, frozen while the message is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantIdx <= '0;
      msiHart  <= '0;
      msiGuest <= '0;
      msiId    <= '0;
    end else if (strobe.loadGen) begin
      msiHart  <= genValue[HART_LSB +: HART_W];
      msiGuest <= '0;
      msiId    <= genValue[ID_LSB +: ID_W];
    end else if (strobe.loadSrc) begin
      grantIdx <= readyIdx;
      msiHart  <= tgtArr[readyIdx][HART_LSB +: HART_W];
      msiGuest <= tgtArr[readyIdx][GUEST_LSB +: GUEST_W];
      msiId    <= tgtArr[readyIdx][ID_LSB +: ID_W];
    end
  end

endmodule

// File: rtl/msi_fwd_control.sv
module msi_fwd_control
  import msi_fwd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        genPending,
  input  logic        readyAny,
  input  logic        domainEn,
  input  logic        msiReady,
  output fwd_strobe_t strobe,
  output logic        msiValid,
  output logic        grantIsGen
);

  typedef enum logic {ST_IDLE, ST_HOLD} fwd_state_e;
  fwd_state_e state;

  always_comb begin
    strobe = '0;
    if (state == ST_IDLE) begin
      if (genPending)               strobe.loadGen = 1'b1;
      else if (domainEn && readyAny) strobe.loadSrc = 1'b1;
    end else if (msiReady && !grantIsGen) begin
      strobe.ackSrc = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      grantIsGen <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (strobe.loadGen || strobe.loadSrc) begin
          state      <= ST_HOLD;
          grantIsGen <= strobe.loadGen;
        end
        ST_HOLD: if (msiReady) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign msiValid = (state == ST_HOLD);

endmodule

// File: rtl/msi_fwd_engine.sv
module msi_fwd_engine
  import msi_fwd_pkg::*;
#(
  parameter int NUM_SRC = 24,
  localparam int IDX_W  = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [2:0]         cmdOp,
  input  logic [IDX_W-1:0]   cmdIdx,
  input  logic [31:0]        cmdData,
  input  logic               evtValid,
  input  logic [IDX_W-1:0]   evtIdx,
  output logic               msiValid,
  input  logic               msiReady,
  output logic [13:0]        msiHart,
  output logic [5:0]         msiGuest,
  output logic [10:0]        msiId,
  input  logic [IDX_W-1:0]   tgtRdIdx,
  output logic [31:0]        tgtRdData,
  output logic [31:0]        genValue
);

  fwd_strobe_t      strobe;
  logic             domainEn, genPending, readyAny, grantIsGen;
  logic             loadSrcSig, ackSrcSig;
  logic [IDX_W-1:0] readyIdx, grantIdx;
  logic [(1<<IDX_W)-1:0] pendVec, enVec;

  assign loadSrcSig = strobe.loadSrc;
  assign ackSrcSig  = strobe.ackSrc;

  msi_fwd_control u_ctrl (
    .clk(clk), .rstN(rstN),
    .genPending(genPending), .readyAny(readyAny), .domainEn(domainEn),
    .msiReady(msiReady), .strobe(strobe), .msiValid(msiValid),
    .grantIsGen(grantIsGen)
  );

  msi_fwd_datapath #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdIdx(cmdIdx), .cmdData(cmdData),
    .evtValid(evtValid), .evtIdx(evtIdx), .strobe(strobe), .tgtRdIdx(tgtRdIdx),
    .domainEn(domainEn), .genPending(genPending), .readyAny(readyAny),
    .readyIdx(readyIdx), .grantIdx(grantIdx),
    .msiHart(msiHart), .msiGuest(msiGuest), .msiId(msiId),
    .tgtRdData(tgtRdData), .genValue(genValue),
    .pendVec(pendVec), .enVec(enVec)
  );

endmodule

// File: rtl/msi_fwd_checker.sv
module msi_fwd_checker
  import msi_fwd_pkg::*;
#(
  parameter int NUM_SRC = 24,
  localparam int IDX_W  = $clog2(NUM_SRC + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               msiValid,
  input logic               msiReady,
  input logic [13:0]        msiHart,
  input logic [5:0]         msiGuest,
  input logic [10:0]        msiId,
  input logic               grantIsGen,
  input logic               loadSrc,
  input logic               domainEn,
  input logic [31:0]        tgtRdData,
  input logic [31:0]        genValue,
  input logic [(1<<IDX_W)-1:0] pendVec,
  input logic [IDX_W-1:0]   grantIdx,
  input logic               evtValid,
  input logic [IDX_W-1:0]   evtIdx,
  input logic               cmdValid,
  input logic [2:0]         cmdOp,
  input logic [IDX_W-1:0]   cmdIdx
);

  logic             ackD, reSetD;
  logic [IDX_W-1:0] ackIdxD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackD    <= 1'b0;
      reSetD  <= 1'b0;
      ackIdxD <= '0;
    end else begin
      ackD    <= msiValid && msiReady && !grantIsGen;
      ackIdxD <= grantIdx;
      reSetD  <= (evtValid && evtIdx == grantIdx) ||
                 (cmdValid && cmdOp == OP_SETPEND && cmdIdx == grantIdx);
    end
  end

  // R1
  grant_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadSrc |-> domainEn);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msiValid && !msiReady) |=> (msiValid && $stable(msiHart) &&
                                 $stable(msiGuest) && $stable(msiId)));

  // R8
  gen_guest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msiValid && grantIsGen) |-> (msiGuest == '0));

  // R8
  gen_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (genValue & GUEST_FIELD) == '0);

  // R4
  tgt_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tgtRdData & ~TGT_KEEP) == '0);

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackD && !reSetD) |-> !pendVec[ackIdxD]);

  // R9
  slot_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pendVec[0]);

endmodule

bind msi_fwd_engine msi_fwd_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rstN(rstN), .msiValid(msiValid), .msiReady(msiReady),
  .msiHart(msiHart), .msiGuest(msiGuest), .msiId(msiId),
  .grantIsGen(grantIsGen), .loadSrc(loadSrcSig), .domainEn(domainEn),
  .tgtRdData(tgtRdData), .genValue(genValue), .pendVec(pendVec),
  .grantIdx(grantIdx), .evtValid(evtValid), .evtIdx(evtIdx),
  .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdIdx(cmdIdx)
);

// File: tb/test_msi_fwd_engine.sv
`timescale 1ns/1ps
module test_msi_fwd_engine;

  localparam int NUM_SRC = 24;
  localparam int IDX_W   = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd7;
  logic [IDX_W-1:0] cmdIdx = '0;
  logic [31:0] cmdData = '0;
  logic evtValid = 1'b0;
  logic [IDX_W-1:0] evtIdx = '0;
  logic msiValid;
  logic msiReady = 1'b0;
  logic [13:0] msiHart;
  logic [5:0] msiGuest;
  logic [10:0] msiId;
  logic [IDX_W-1:0] tgtRdIdx = '0;
  logic [31:0] tgtRdData;
  logic [31:0] genValue;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  msi_fwd_engine #(.NUM_SRC(NUM_SRC)) i_msi_fwd_engine (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdIdx(cmdIdx), .cmdData(cmdData), .evtValid(evtValid), .evtIdx(evtIdx),
    .msiValid(msiValid), .msiReady(msiReady), .msiHart(msiHart),
    .msiGuest(msiGuest), .msiId(msiId), .tgtRdIdx(tgtRdIdx),
    .tgtRdData(tgtRdData), .genValue(genValue)
  );

  function automatic logic [31:0] mkTgt(int hart, int guest, int id);
    return {14'(hart), 6'(guest), 1'b0, 11'(id)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(input int op, input int idx, input logic [31:0] data);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'(op); cmdIdx = IDX_W'(idx); cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd7;
  endtask

  task automatic event1(input int idx);
    @(negedge clk);
    evtValid = 1'b1; evtIdx = IDX_W'(idx);
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  // wait for a message, compare fields, accept it
  task automatic takeMsi(input logic [31:0] tgt, input string req);
    bit seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (msiValid) seen = 1;
    end
    check(seen, {req, " message present"}, 32'(msiValid), 32'd1);
    if (seen) begin
      check(msiHart == tgt[31:18], {req, " hart"}, 32'(msiHart), 32'(tgt[31:18]));
      check(msiGuest == tgt[17:12], {req, " guest"}, 32'(msiGuest), 32'(tgt[17:12]));
      check(msiId == tgt[10:0], {req, " identity"}, 32'(msiId), 32'(tgt[10:0]));
      msiReady = 1'b1;
      @(negedge clk);
      msiReady = 1'b0;
    end
  endtask

  task automatic expectQuiet(input int n, input string req);
    bit quiet = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (msiValid) quiet = 0;
    end
    check(quiet, {req, " no message"}, 32'(!quiet), 32'd0);
  endtask

  task automatic readTgt(input int idx, input logic [31:0] exp, input string req);
    @(negedge clk);
    tgtRdIdx = IDX_W'(idx);
    #1;
    check(tgtRdData == exp, req, tgtRdData, exp);
  endtask

  task automatic tReset;
    @(negedge clk);
    check(msiValid == 1'b0, "R11 valid low", 32'(msiValid), 32'd0);
    check(genValue == 32'd0, "R11 gen word", genValue, 32'd0);
    readTgt(1, 32'd0, "R11 destination word");
  endtask

  task automatic tTargetMask;
    cmd(1, 4, 32'hFFFF_FFFF);
    readTgt(4, 32'hFFFF_F7FF, "R4 masked destination");
  endtask

  task automatic tBasic;
    logic [31:0] t = mkTgt(14'h2A5, 6'h15, 11'h3C7);
    cmd(0, 0, 32'd1);
    cmd(1, 4, t);
    cmd(4, 4, 32'd0);
    event1(4);
    takeMsi(t, "R3 R10 event forward");
    expectQuiet(10, "R5 single message");
  endtask

  task automatic tDomainOff;
    logic [31:0] t = mkTgt(14'h011, 6'h02, 11'h044);
    cmd(0, 0, 32'd0);
    cmd(1, 6, t);
    cmd(4, 6, 32'd0);
    cmd(2, 6, 32'd0);
    expectQuiet(10, "R1 domain off");
    cmd(0, 0, 32'd1);
    takeMsi(t, "R1 domain on");
  endtask

  task automatic tNeedEnable;
    logic [31:0] t = mkTgt(14'h3FFF, 6'h3F, 11'h7FF);
    cmd(1, 9, t);
    cmd(2, 9, 32'd0);
    expectQuiet(10, "R2 disabled source");
    cmd(4, 9, 32'd0);
    takeMsi(t, "R2 enable late");
  endtask

  task automatic tCancel;
    cmd(0, 0, 32'd0);
    cmd(1, 11, mkTgt(1, 1, 1));
    cmd(4, 11, 32'd0);
    cmd(2, 11, 32'd0);
    cmd(3, 11, 32'd0);
    cmd(1, 12, mkTgt(2, 2, 2));
    cmd(4, 12, 32'd0);
    cmd(2, 12, 32'd0);
    cmd(5, 12, 32'd0);
    cmd(0, 0, 32'd1);
    expectQuiet(10, "R12 cancelled");
    cmd(3, 12, 32'd0);
  endtask

  task automatic tOrder;
    logic [31:0] a = mkTgt(14'h100, 6'h01, 11'h003);
    logic [31:0] b = mkTgt(14'h200, 6'h02, 11'h007);
    logic [31:0] c = mkTgt(14'h300, 6'h03, 11'h014);
    cmd(0, 0, 32'd0);
    cmd(1, 20, c); cmd(1, 3, a); cmd(1, 7, b);
    cmd(4, 20, 0); cmd(4, 3, 0); cmd(4, 7, 0);
    cmd(2, 7, 0);  cmd(2, 20, 0); cmd(2, 3, 0);
    cmd(0, 0, 32'd1);
    takeMsi(a, "R6 first");
    takeMsi(b, "R6 second");
    takeMsi(c, "R6 third");
    expectQuiet(5, "R6 drained");
  endtask

  task automatic tHoldGen;
    logic [31:0] t5 = mkTgt(14'h055, 6'h05, 11'h055);
    logic [31:0] t2 = mkTgt(14'h022, 6'h0A, 11'h122);
    logic [31:0] g  = 32'hABCD_F123;
    logic [31:0] gExp = {g[31:18], 6'd0, 1'b0, g[10:0]};
    bit stable = 1;
    cmd(1, 5, t5);
    cmd(4, 5, 0);
    cmd(2, 5, 0);
    repeat (3) @(negedge clk);
    check(msiValid == 1'b1, "R7 held valid", 32'(msiValid), 32'd1);
    cmd(1, 5, mkTgt(0, 0, 0));
    cmd(6, 0, g);
    cmd(1, 2, t2); cmd(4, 2, 0); cmd(2, 2, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!msiValid || msiId != t5[10:0] || msiHart != t5[31:18]) stable = 0;
    end
    check(stable, "R7 fields stable", 32'(msiId), 32'(t5[10:0]));
    check(genValue == 32'hABCC_0123, "R8 stored gen word", genValue, 32'hABCC_0123);
    takeMsi(t5, "R7 held message");
    takeMsi(gExp, "R8 gen first");
    takeMsi(t2, "R8 source after gen");
  endtask

  task automatic tGenOff;
    logic [31:0] g = 32'h0004_07FF;
    cmd(0, 0, 32'd0);
    cmd(6, 0, g);
    takeMsi({g[31:18], 6'd0, 1'b0, g[10:0]}, "R8 gen while domain off");
    cmd(0, 0, 32'd1);
  endtask

  task automatic tIgnoreIdx;
    cmd(1, 0, 32'hFFFF_FFFF);
    cmd(1, 25, 32'hFFFF_FFFF);
    cmd(1, 31, 32'hFFFF_FFFF);
    cmd(4, 0, 0); cmd(4, 25, 0); cmd(4, 31, 0);
    cmd(2, 0, 0); cmd(2, 25, 0); cmd(2, 31, 0);
    event1(25);
    expectQuiet(10, "R9 bad index");
    readTgt(25, 32'd0, "R9 read above range");
    readTgt(0, 32'd0, "R9 read slot zero");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tTargetMask();
    tBasic();
    tDomainOff();
    tNeedEnable();
    tCancel();
    tOrder();
    tHoldGen();
    tGenOff();
    tIgnoreIdx();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule